// File: doc/BRIEF.md
# Serial Peripheral Master with Refillable Exchange Control

This block is the shifting engine of a serial peripheral (SPI) master. Software loads 32-bit words into a transmit queue through a push port, programs a burst length of 1 to 4096 bits, and pulses a set request on the exchange control bit. The engine then clocks the words out on MOSI through a left-aligned shift register, most significant valid bit first. It collects MISO into a receive word that is presented with a one-cycle valid pulse. The serial clock runs in SPI mode 0 at the system clock divided by twice a programmable half-period count.

A burst may be longer than the queue can hold. When the queue and the shift register both run dry before the burst count is reached, the engine pauses with chip select still low and drops the exchange bit. Software refills the queue and sets the exchange bit again. That fresh rising edge resumes the same burst at the next bit. The exchange bit is cleared by an empty queue, not by the end of a burst. If words remain when a burst ends, the bit stays high and the next burst starts by itself after chip select has been released.

The controller has five states. ST_IDLE has chip select high. ST_LOW and ST_HIGH are the two halves of one bit period. ST_PAUSE means the burst is unfinished and the queue is empty. ST_TAIL is one serial clock period of chip select hold after the last bit. The transitions are:
- IDLE to LOW when the queue is non-empty and either a set request arrives or the exchange bit is still high. This starts a new burst.
- LOW to HIGH at the end of the half-period. MISO is sampled on this transition.
- HIGH to LOW when the word has bits left, or when the word is done and the queue can supply the next word.
- HIGH to PAUSE when the word is done, the burst is not, and the queue is empty.
- HIGH to TAIL on the last bit of the burst.
- PAUSE to LOW on a set request with a non-empty queue.
- TAIL to IDLE after two half-periods.

Top module: `spi_xfer_master`

## Requirements
- R1: SCLK is low outside bits. Each bit is a low phase of H system clocks followed by a high phase of H system clocks, where H is `half_div`, and a value of 0 acts as 1. MISO is captured on the low-to-high transition, and MOSI changes only on a word load or on a high-to-low transition.
- R2: A burst carries `len_m1`+1 bits. Each word taken from the queue supplies min(32, bits remaining) bits. Those are its low-order bits, sent most significant first, so MOSI shows word bit k-1 first for a k-bit word.
- R3: cs_n falls together with the first bit of a burst. It stays low through every bit and every pause, and rises 2H clocks after the final high phase ends.
- R4: A set request is accepted only in IDLE, PAUSE or TAIL and only while the queue holds a word. Otherwise xch keeps its value, and a request made while xch is 0 with an empty queue leaves xch at 0 and the shifting state unchanged.
- R5: xch falls exactly when the last queued word has been fully shifted out, either on entry to PAUSE or at a burst end with an empty queue. At a burst end with words still queued, xch stays 1 and a new burst of the programmed length starts one clock after the tail.
- R6: In a pause, cs_n stays 0 and xch and SCLK stay 0. After a refill and a set request, the burst continues with its remaining bit count, so the total clocked bits equal the programmed length.
- R7: The queue holds DEPTH words, and fifo_full is 1 when it is full. A push while full is dropped and sets overflow. overflow stays 1 until reset.
- R8: At the end of every word (32 bits, or the last partial word of a burst), rx_valid is 1 for exactly one clock. rx_data then holds the bits captured for that word, right-aligned, with the first captured bit most significant.
- R9: Out of reset, cs_n is 1, and sclk, mosi, xch, rx_valid, overflow and fifo_full are 0.
- R10: A length write takes effect only at the start of the next burst. Writing it during a burst does not change that burst's bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_we | input | 1 | Write strobe for the burst length register |
| len_m1 | input | LEN_W | Burst length minus one |
| half_div | input | DIV_W | SCLK half-period in system clocks (0 acts as 1) |
| xch_set | input | 1 | Write-one request to set the exchange bit |
| xch | output | 1 | Exchange bit |
| push_valid | input | 1 | Push a word into the transmit queue |
| push_data | input | WORD_W | Word to push |
| fifo_full | output | 1 | Transmit queue full |
| overflow | output | 1 | Sticky flag for a push dropped on a full queue |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| rx_valid | output | 1 | One-cycle receive word strobe |
| rx_data | output | WORD_W | Received word, right-aligned |

## Verification
The bench builds the block with a four-word queue and a 4-bit divider field, while keeping 32-bit words and the 12-bit length field. The small queue makes a 200-bit burst outrun 128 bits of queued data, which forces a pause, an ignored set request on an empty queue, and a resume. It also lets a five-word push reach the full and overflow conditions within a few cycles. Half-period values of 0, 1, 2 and 3 exercise the divider floor and several bit timings. Lengths of 1, 8, 40, 64 and 200 bits exercise single-bit bursts, partial final words and back-to-back bursts that start on their own.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_PAUSE,
        ST_TAIL
    } xfer_state_t;

endpackage

// File: rtl/spi_xfer_fifo.sv
module spi_xfer_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            end
            if (do_pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_xfer_timer.sv
module spi_xfer_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;

    assign hit = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    parameter int LEN_W  = 12,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              xch_set,
    output logic              xch,
    input  logic              push_valid,
    input  logic [WORD_W-1:0] push_data,
    output logic              fifo_full,
    output logic              overflow,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data
);
    localparam int BC_W = LEN_W + 1;
    localparam int WB_W = $clog2(WORD_W + 1);
    localparam int TM_W = DIV_W + 1;

    xfer_state_t state, state_n;

    logic [WORD_W-1:0] q_head;
    logic              q_empty, q_full, q_drop, q_pop;

    logic [LEN_W-1:0]  len_r;
    logic [BC_W-1:0]   bits_left, bits_after;
    logic [WB_W-1:0]   wbits, load_bits;
    logic [WORD_W-1:0] shreg, load_word, rx_sh;

    logic [DIV_W-1:0]  half_eff;
    logic [TM_W-1:0]   tm_limit;
    logic              tm_run, tm_hit;

    logic lo_end, hi_end, word_end, burst_end;
    logic start_ok, new_burst, resume, cont, go_pause, load;

    spi_xfer_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .drop      (q_drop)
    );

    spi_xfer_timer #(.CW(TM_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tm_run),
        .limit (tm_limit),
        .hit   (tm_hit)
    );

    // phase timing
    assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tm_run   = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL);
    assign tm_limit = (state == ST_TAIL) ? ({half_eff, 1'b0} - TM_W'(1))
                                         : ({1'b0, half_eff} - TM_W'(1));

    // event decode
    assign lo_end    = (state == ST_LOW)  && tm_hit;
    assign hi_end    = (state == ST_HIGH) && tm_hit;
    assign word_end  = hi_end && (wbits == WB_W'(1));
    assign burst_end = word_end && (bits_left == BC_W'(1));
    assign start_ok  = !q_empty && (xch_set || xch);
    assign new_burst = (state == ST_IDLE)  && start_ok;
    assign resume    = (state == ST_PAUSE) && start_ok;
    assign cont      = word_end && !burst_end && !q_empty;
    assign go_pause  = word_end && !burst_end && q_empty;
    assign load      = new_burst || resume || cont;
    assign q_pop     = load;

    assign bits_after = new_burst ? (BC_W'(len_r) + BC_W'(1))
                      : (hi_end ? bits_left - BC_W'(1) : bits_left);
    assign load_bits  = (bits_after > BC_W'(WORD_W)) ? WB_W'(WORD_W)
                                                     : bits_after[WB_W-1:0];
    assign load_word  = q_head << (WB_W'(WORD_W) - load_bits);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (new_burst) state_n = ST_LOW;
            ST_LOW:   if (tm_hit)    state_n = ST_HIGH;
            ST_HIGH: begin
                if (tm_hit) begin
                    if (burst_end)     state_n = ST_TAIL;
                    else if (go_pause) state_n = ST_PAUSE;
                    else               state_n = ST_LOW;
                end
            end
            ST_PAUSE: if (resume)    state_n = ST_LOW;
            ST_TAIL:  if (tm_hit)    state_n = ST_IDLE;
            default:                 state_n = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_r     <= '0;
            bits_left <= '0;
            wbits     <= '0;
            shreg     <= '0;
            rx_sh     <= '0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            xch       <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            if (len_we) begin
                len_r <= len_m1;
            end
            bits_left <= bits_after;
            if (load) begin
                shreg <= load_word;
                wbits <= load_bits;
                rx_sh <= '0;
            end else if (hi_end) begin
                shreg <= shreg << 1;
                wbits <= wbits - WB_W'(1);
            end
            if (lo_end) begin
                rx_sh <= {rx_sh[WORD_W-2:0], miso};
            end
            rx_valid <= word_end;
            if (word_end) begin
                rx_data <= rx_sh;
            end
            if (go_pause || (burst_end && q_empty)) begin
                xch <= 1'b0;
            end else if (load) begin
                xch <= 1'b1;
            end else if ((state == ST_TAIL) && xch_set && !q_empty) begin
                xch <= 1'b1;
            end
            if (q_drop) begin
                overflow <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sclk      = (state == ST_HIGH);
        cs_n      = (state == ST_IDLE);
        mosi      = ((state == ST_LOW) || (state == ST_HIGH)) ? shreg[WORD_W-1] : 1'b0;
        fifo_full = q_full;
    end
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk (
    input logic clk,
    input logic rst_n,
    input logic xch,
    input logic xch_set,
    input logic cs_n,
    input logic sclk,
    input logic rx_valid,
    input logic overflow,
    input logic q_empty
);
    // R1 / R3: serial clock only pulses inside a framed burst
    a_r1_sclk_framed: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R5: the exchange bit only drops once the queue has been drained
    a_r5_xch_falls_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xch) |-> $past(q_empty));

    // R4: a set request on an empty queue cannot raise the exchange bit
    a_r4_set_ignored_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (xch_set && !xch && q_empty) |=> !xch);

    // R7: overflow is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: receive strobe lasts one clock
    a_r8_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind spi_xfer_master spi_xfer_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xch      (xch),
    .xch_set  (xch_set),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .rx_valid (rx_valid),
    .overflow (overflow),
    .q_empty  (q_empty)
);

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 32;
    localparam int DEPTH  = 4;
    localparam int LEN_W  = 12;
    localparam int DIV_W  = 4;

    localparam int M_IDLE = 0, M_LOW = 1, M_HIGH = 2, M_PAUSE = 3, M_TAIL = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              len_we;
    logic [LEN_W-1:0]  len_m1;
    logic [DIV_W-1:0]  half_div;
    logic              xch_set;
    logic              xch;
    logic              push_valid;
    logic [WORD_W-1:0] push_data;
    logic              fifo_full, overflow, sclk, mosi, miso, cs_n, rx_valid;
    logic [WORD_W-1:0] rx_data;

    int checks = 0;
    int errors = 0;
    int rise_cnt = 0;
    logic prev_sclk = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    spi_xfer_master #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_m1(len_m1), .half_div(half_div),
        .xch_set(xch_set), .xch(xch), .push_valid(push_valid), .push_data(push_data),
        .fifo_full(fifo_full), .overflow(overflow), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // reference model state
    int          m_st, m_cnt, m_left, m_wb, m_len;
    logic [31:0] m_word, m_rx, e_rxd;
    logic [31:0] m_q[$];
    bit          m_xch, m_ovf, e_rxv;

    task automatic m_load();
        logic [31:0] w;
        w = m_q.pop_front();
        m_wb = (m_left > WORD_W) ? WORD_W : m_left;
        m_word = (m_wb == 32) ? w : (w & ((32'd1 << m_wb) - 32'd1));
        m_rx = '0;
    endtask

    always @(posedge clk) begin
        bit emp, ful;
        int hh;
        if (!rst_n) begin
            m_st = M_IDLE; m_cnt = 0; m_left = 0; m_wb = 0; m_len = 0;
            m_word = '0; m_rx = '0; e_rxd = '0; m_xch = 0; m_ovf = 0; e_rxv = 0;
            m_q.delete();
        end else begin
            emp = (m_q.size() == 0);
            ful = (m_q.size() == DEPTH);
            hh  = (half_div == 0) ? 1 : int'(half_div);
            e_rxv = 0;
            case (m_st)
                M_IDLE: if (!emp && (xch_set || m_xch)) begin
                    m_left = m_len + 1; m_load(); m_xch = 1; m_st = M_LOW; m_cnt = 0;
                end
                M_LOW: if (m_cnt == hh - 1) begin
                    m_rx = {m_rx[30:0], miso}; m_st = M_HIGH; m_cnt = 0;
                end else m_cnt++;
                M_HIGH: if (m_cnt == hh - 1) begin
                    m_cnt = 0; m_left--; m_wb--;
                    if (m_wb == 0) begin
                        e_rxv = 1; e_rxd = m_rx;
                        if (m_left == 0) begin
                            m_st = M_TAIL;
                            if (emp) m_xch = 0;
                        end else if (!emp) begin
                            m_load(); m_st = M_LOW;
                        end else begin
                            m_st = M_PAUSE; m_xch = 0;
                        end
                    end else m_st = M_LOW;
                end else m_cnt++;
                M_PAUSE: if (!emp && xch_set) begin
                    m_load(); m_xch = 1; m_st = M_LOW; m_cnt = 0;
                end
                M_TAIL: begin
                    if (xch_set && !emp) m_xch = 1;
                    if (m_cnt == 2 * hh - 1) begin m_st = M_IDLE; m_cnt = 0; end
                    else m_cnt++;
                end
                default: m_st = M_IDLE;
            endcase
            if (push_valid) begin
                if (ful) m_ovf = 1;
                else m_q.push_back(push_data);
            end
            if (len_we) m_len = int'(len_m1);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_mosi;
            chk(sclk == (m_st == M_HIGH), "R1", "sclk", sclk, m_st == M_HIGH);
            chk(cs_n == (m_st == M_IDLE), "R3", "cs_n", cs_n, m_st == M_IDLE);
            if (m_st == M_LOW || m_st == M_HIGH) begin
                exp_mosi = m_word[m_wb - 1];
                chk(mosi == exp_mosi, "R2", "mosi", mosi, exp_mosi);
            end
            chk(xch == m_xch, "R5", "xch", xch, m_xch);
            chk(rx_valid == e_rxv, "R8", "rx_valid", rx_valid, e_rxv);
            chk(rx_data == e_rxd, "R8", "rx_data", rx_data, e_rxd);
            chk(fifo_full == (m_q.size() == DEPTH), "R7", "fifo_full", fifo_full, m_q.size() == DEPTH);
            chk(overflow == m_ovf, "R7", "overflow", overflow, m_ovf);
            if (sclk && !prev_sclk) rise_cnt++;
        end
        prev_sclk = sclk;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = lfsr[0];
    end

    task automatic push(input logic [31:0] w);
        @(negedge clk); push_valid = 1'b1; push_data = w;
        @(negedge clk); push_valid = 1'b0;
    endtask

    task automatic set_xch();
        @(negedge clk); xch_set = 1'b1;
        @(negedge clk); xch_set = 1'b0;
    endtask

    task automatic set_len(input int n);
        @(negedge clk); len_we = 1'b1; len_m1 = LEN_W'(n);
        @(negedge clk); len_we = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(m_st == M_IDLE && !m_xch));
        @(negedge clk);
    endtask

    task automatic wait_pause();
        do @(negedge clk); while (m_st != M_PAUSE);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; len_we = 0; len_m1 = '0; half_div = DIV_W'(2);
        xch_set = 0; push_valid = 0; push_data = '0; miso = 0;
        repeat (3) @(negedge clk);
        // R9 reset values
        chk(cs_n == 1'b1, "R9", "cs_n in reset", cs_n, 1);
        chk(sclk == 1'b0 && mosi == 1'b0, "R9", "sclk/mosi in reset", {sclk, mosi}, 0);
        chk(xch == 1'b0 && rx_valid == 1'b0, "R9", "xch/rx_valid in reset", {xch, rx_valid}, 0);
        chk(overflow == 1'b0 && fifo_full == 1'b0, "R9", "flags in reset", {overflow, fifo_full}, 0);
        rst_n = 1'b1;

        // 40-bit burst: full word then an 8-bit partial word (R2)
        set_len(39);
        push(32'hA5C3_0F96); push(32'h1234_5678);
        rise_cnt = 0;
        set_xch();
        wait_idle();
        chk(rise_cnt == 40, "R2", "bits in 40-bit burst", rise_cnt, 40);

        // set request with empty queue while idle (R4)
        set_xch();
        repeat (2) @(negedge clk);
        chk(xch == 1'b0 && cs_n == 1'b1, "R4", "idle set on empty queue", {xch, cs_n}, 2'b01);

        // burst longer than the queue: pause, ignored set, resume (R6)
        set_len(199);
        push(32'hDEAD_BEEF); push(32'h0F0F_F0F0); push(32'h8000_0001); push(32'h7E7E_8181);
        rise_cnt = 0;
        set_xch();
        wait_pause();
        chk(cs_n == 1'b0 && xch == 1'b0, "R6", "pause keeps cs low, xch low", {cs_n, xch}, 0);
        chk(rise_cnt == 128, "R6", "bits before pause", rise_cnt, 128);
        set_xch();
        repeat (4) @(negedge clk);
        chk(xch == 1'b0 && sclk == 1'b0 && rise_cnt == 128, "R4", "set during empty pause ignored",
            rise_cnt, 128);
        push(32'hCAFE_F00D); push(32'h3C3C_C3C3); push(32'h0000_00A7);
        set_xch();
        wait_idle();
        chk(rise_cnt == 200, "R6", "resumed burst total bits", rise_cnt, 200);

        // overflow and back-to-back bursts with xch held (R7, R5)
        half_div = DIV_W'(1);
        set_len(63);
        @(negedge clk); push_valid = 1'b1;
        for (int i = 0; i < 5; i++) begin
            push_data = 32'h1111_1111 * (i + 1);
            @(negedge clk);
        end
        push_valid = 1'b0;
        chk(fifo_full == 1'b1 && overflow == 1'b1, "R7", "full and overflow after 5 pushes",
            {fifo_full, overflow}, 2'b11);
        rise_cnt = 0;
        set_xch();
        wait_idle();
        chk(rise_cnt == 128, "R5", "two bursts from one set", rise_cnt, 128);
        chk(overflow == 1'b1 && fifo_full == 1'b0, "R7", "overflow sticky after drain",
            {overflow, fifo_full}, 2'b10);

        // length write in mid-burst (R10)
        set_len(39);
        push(32'h5555_AAAA); push(32'h0000_00C4);
        rise_cnt = 0;
        set_xch();
        repeat (10) @(negedge clk);
        set_len(7);
        wait_idle();
        chk(rise_cnt == 40, "R10", "mid-burst length write ignored", rise_cnt, 40);
        push(32'h0000_005A);
        rise_cnt = 0;
        set_xch();
        wait_idle();
        chk(rise_cnt == 8, "R10", "new length at next burst", rise_cnt, 8);

        // single-bit burst with half_div 0 (R1, R2)
        half_div = '0;
        set_len(0);
        push(32'h0000_0001);
        rise_cnt = 0;
        set_xch();
        wait_idle();
        chk(rise_cnt == 1, "R2", "single-bit burst", rise_cnt, 1);

        // slower clock, 45-bit burst (R1)
        half_div = DIV_W'(3);
        set_len(44);
        push(32'h9ABC_DEF0); push(32'h0000_1F2E);
        rise_cnt = 0;
        set_xch();
        wait_idle();
        chk(rise_cnt == 45, "R1", "bits at half period 3", rise_cnt, 45);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule